// File: doc/BRIEF.md
# TDM Serializer Loopback Router

This block sits between the transmit and receive serializer lanes of a multichannel TDM audio serial port and the pad ring. In normal operation it passes each pad input straight to the receive lane of the same index and passes the receive bit clock and frame sync in from their pins. When loopback self-test is selected and the transmit side is framing TDM with 2 to 32 slots, each receive lane of one parity is fed from the transmit lane next to it. The receive section then runs from the transmit bit clock and frame sync. Software can then compare the words it received with the words it sent.

The loop can close inside the block or at the pad level. In the pad-level case the receive lane reads the input buffer of the transmit pin, so the pin function and direction bits must really configure that pin as a driven output. All control inputs are sampled only in the clock cycle in which the transmit frame-start strobe is high. A change made in the middle of a frame therefore never breaks up a slot. A configuration-error flag reports loopback running without the synchronous clock setup.

Top module: `lbk_router`

## Requirements
- R1: After reset, `lb_active_o` and `cfg_err_o` are 0, every `pad_oe_o` bit is 0, every `rx_data_o[i]` equals `pad_in_i[i]`, and the receive clock and frame sync come from their pins.
- R2: Loopback is active only when control bit 0 (enable) is 1 and `tx_mode_i` lies in 2..32. The values 0, 0x180 and 33 leave `lb_active_o` at 0 and normal routing in place.
- R3: When active with control bit 1 (ordering) = 0, receive lane 2k takes transmit lane 2k+1, and receive lane 2k+1 keeps `pad_in_i[2k+1]`.
- R4: When active with ordering = 1, receive lane 2k+1 takes transmit lane 2k, and receive lane 2k keeps `pad_in_i[2k]`.
- R5: With control bit 4 = 0 (internal loop), the routing of R3/R4 uses `tx_data_i` directly, whatever the pin function and direction bits are.
- R6: `pad_out_o` always equals `tx_data_i`. `pad_oe_o[i]` is 1 exactly when the registered function bit is 0 (serial port) and the registered direction bit is 1 (output).
- R7: With control bit 4 = 1 (pad-level loop), the source of each routed receive lane is `pad_in_i` of the transmit lane that R3/R4 name, not `tx_data_i`.
- R8: While loopback is active, `rx_bclk_o` follows `tx_bclk_i` and `rx_fs_o` follows `tx_fs_i`. Otherwise they follow `rx_bclk_pin_i` and `rx_fs_pin_i`.
- R9: `cfg_err_o` is 1 exactly when loopback is active and the clock setup is not synchronous, that is, control bits 3:2 are not 1 or `tx_async_i` is 1.
- R10: Control word, mode, async, function and direction inputs are captured only at a rising `clk` edge where `tx_fs_i` is 1. At any other edge they have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; `tx_fs_i` is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| lb_ctrl_i | input | 8 | Loopback control: bit0 enable, bit1 ordering, bits3:2 clock mode, bit4 pad-level |
| tx_mode_i | input | 9 | Transmit framing mode (slot count in TDM; 0 burst, 0x180 DIT) |
| tx_async_i | input | 1 | Transmit clock control asynchronous bit |
| pin_func_i | input | NUM_LANES | Per-pin function, 0 = serial port, 1 = GPIO |
| pin_dir_i | input | NUM_LANES | Per-pin direction, 1 = output |
| tx_data_i | input | NUM_LANES | Transmit serializer output bits |
| pad_in_i | input | NUM_LANES | Pad input buffer bits |
| tx_bclk_i | input | 1 | Transmit bit clock |
| tx_fs_i | input | 1 | Transmit frame sync (one-cycle frame-start strobe) |
| rx_bclk_pin_i | input | 1 | Receive bit clock from its pin |
| rx_fs_pin_i | input | 1 | Receive frame sync from its pin |
| rx_data_o | output | NUM_LANES | Receive serializer input bits |
| rx_bclk_o | output | 1 | Receive bit clock in use |
| rx_fs_o | output | 1 | Receive frame sync in use |
| pad_out_o | output | NUM_LANES | Pad output data |
| pad_oe_o | output | NUM_LANES | Pad output enables |
| lb_active_o | output | 1 | Loopback routing in effect |
| cfg_err_o | output | 1 | Loopback active without synchronous clock setup |

## Verification
The hardest case is the pad-level loop. There, correct receive data depends on the registered direction bits turning the right pads into outputs, and the pad model must feed each pad's own output back to its input. The bench models that pad ring and sends distinct 16-bit words on every lane in both orderings. It also runs a setup with the direction bits wrong, where the receive lanes must show the foreign words applied outside the pad rather than the transmitted ones. A second hard case is a control change that arrives between frame starts. The bench changes the inputs without a strobe, confirms that the outputs keep their old behaviour, and only then supplies the strobe.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    localparam int CTRL_W   = 8;
    localparam int MODE_W   = 9;
    localparam int CB_EN    = 0;
    localparam int CB_ORD   = 1;
    localparam int CB_CKM   = 2;
    localparam int CKM_W    = 2;
    localparam int CB_LVL   = 4;
    localparam int TDM_MIN  = 2;
    localparam int TDM_MAX  = 32;
    localparam logic [CKM_W-1:0] CKM_SYNC = 2'd1;

    typedef struct packed {
        logic              en;
        logic              order;
        logic              pad_lvl;
        logic [CKM_W-1:0]  ckmode;
        logic [MODE_W-1:0] mode;
        logic              async_clk;
    } lbk_cfg_t;

    function automatic logic mode_is_tdm(input logic [MODE_W-1:0] m);
        return (m >= MODE_W'(TDM_MIN)) && (m <= MODE_W'(TDM_MAX));
    endfunction

endpackage

// File: rtl/lbk_cfg_stage.sv
module lbk_cfg_stage
    import lbk_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_start_i,
    input  logic [CTRL_W-1:0]           ctrl_i,
    input  logic [MODE_W-1:0]           mode_i,
    input  logic                        async_i,
    input  logic [NUM_LANES-1:0]        func_i,
    input  logic [NUM_LANES-1:0]        dir_i,
    output logic                        active_o,
    output logic                        order_o,
    output logic                        pad_lvl_o,
    output logic                        cfg_err_o,
    output logic [NUM_LANES-1:0]        func_o,
    output logic [NUM_LANES-1:0]        dir_o
);

    typedef struct packed {
        lbk_cfg_t             cfg;
        logic [NUM_LANES-1:0] func;
        logic [NUM_LANES-1:0] dir;
    } stage_t;

    stage_t st_d, st_q;
    logic   sync_ok;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.cfg.en        = ctrl_i[CB_EN];
            st_d.cfg.order     = ctrl_i[CB_ORD];
            st_d.cfg.pad_lvl   = ctrl_i[CB_LVL];
            st_d.cfg.ckmode    = ctrl_i[CB_CKM +: CKM_W];
            st_d.cfg.mode      = mode_i;
            st_d.cfg.async_clk = async_i;
            st_d.func          = func_i;
            st_d.dir           = dir_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.func <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_ok   = (st_q.cfg.ckmode == CKM_SYNC) && !st_q.cfg.async_clk;
    assign active_o  = st_q.cfg.en && mode_is_tdm(st_q.cfg.mode);
    assign order_o   = st_q.cfg.order;
    assign pad_lvl_o = st_q.cfg.pad_lvl;
    assign cfg_err_o = active_o && !sync_ok;
    assign func_o    = st_q.func;
    assign dir_o     = st_q.dir;

endmodule

// File: rtl/lbk_lane_xbar.sv
module lbk_lane_xbar #(
    parameter int NUM_LANES = 8
) (
    input  logic                 active_i,
    input  logic                 order_i,
    input  logic                 pad_lvl_i,
    input  logic [NUM_LANES-1:0] func_i,
    input  logic [NUM_LANES-1:0] dir_i,
    input  logic [NUM_LANES-1:0] tx_data_i,
    input  logic [NUM_LANES-1:0] pad_in_i,
    output logic [NUM_LANES-1:0] rx_data_o,
    output logic [NUM_LANES-1:0] pad_out_o,
    output logic [NUM_LANES-1:0] pad_oe_o
);

    localparam int NUM_PAIRS = NUM_LANES / 2;

    logic [NUM_LANES-1:0] src_bits;

    // Loop source: transmit bit directly, or the same lane seen back through its pad.
    assign src_bits  = pad_lvl_i ? pad_in_i : tx_data_i;
    assign pad_out_o = tx_data_i;
    assign pad_oe_o  = ~func_i & dir_i;

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        localparam int EV = 2 * k;
        localparam int OD = 2 * k + 1;
        assign rx_data_o[EV] = (active_i && !order_i) ? src_bits[OD] : pad_in_i[EV];
        assign rx_data_o[OD] = (active_i &&  order_i) ? src_bits[EV] : pad_in_i[OD];
    end

endmodule

// File: rtl/lbk_clk_sel.sv
module lbk_clk_sel (
    input  logic active_i,
    input  logic tx_bclk_i,
    input  logic tx_fs_i,
    input  logic rx_bclk_pin_i,
    input  logic rx_fs_pin_i,
    output logic rx_bclk_o,
    output logic rx_fs_o
);

    assign rx_bclk_o = active_i ? tx_bclk_i : rx_bclk_pin_i;
    assign rx_fs_o   = active_i ? tx_fs_i   : rx_fs_pin_i;

endmodule

// File: rtl/lbk_router.sv
module lbk_router
    import lbk_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CTRL_W-1:0]    lb_ctrl_i,
    input  logic [MODE_W-1:0]    tx_mode_i,
    input  logic                 tx_async_i,
    input  logic [NUM_LANES-1:0] pin_func_i,
    input  logic [NUM_LANES-1:0] pin_dir_i,
    input  logic [NUM_LANES-1:0] tx_data_i,
    input  logic [NUM_LANES-1:0] pad_in_i,
    input  logic                 tx_bclk_i,
    input  logic                 tx_fs_i,
    input  logic                 rx_bclk_pin_i,
    input  logic                 rx_fs_pin_i,
    output logic [NUM_LANES-1:0] rx_data_o,
    output logic                 rx_bclk_o,
    output logic                 rx_fs_o,
    output logic [NUM_LANES-1:0] pad_out_o,
    output logic [NUM_LANES-1:0] pad_oe_o,
    output logic                 lb_active_o,
    output logic                 cfg_err_o
);

    logic                 active, order, pad_lvl;
    logic [NUM_LANES-1:0] func_r, dir_r;

    lbk_cfg_stage #(.NUM_LANES(NUM_LANES)) u_cfg (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (tx_fs_i),
        .ctrl_i        (lb_ctrl_i),
        .mode_i        (tx_mode_i),
        .async_i       (tx_async_i),
        .func_i        (pin_func_i),
        .dir_i         (pin_dir_i),
        .active_o      (active),
        .order_o       (order),
        .pad_lvl_o     (pad_lvl),
        .cfg_err_o     (cfg_err_o),
        .func_o        (func_r),
        .dir_o         (dir_r)
    );

    lbk_lane_xbar #(.NUM_LANES(NUM_LANES)) u_xbar (
        .active_i  (active),
        .order_i   (order),
        .pad_lvl_i (pad_lvl),
        .func_i    (func_r),
        .dir_i     (dir_r),
        .tx_data_i (tx_data_i),
        .pad_in_i  (pad_in_i),
        .rx_data_o (rx_data_o),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o)
    );

    lbk_clk_sel u_clk (
        .active_i      (active),
        .tx_bclk_i     (tx_bclk_i),
        .tx_fs_i       (tx_fs_i),
        .rx_bclk_pin_i (rx_bclk_pin_i),
        .rx_fs_pin_i   (rx_fs_pin_i),
        .rx_bclk_o     (rx_bclk_o),
        .rx_fs_o       (rx_fs_o)
    );

    assign lb_active_o = active;

endmodule

// File: rtl/lbk_router_chk.sv
module lbk_router_chk
    import lbk_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MODE_W-1:0]    tx_mode_i,
    input logic [NUM_LANES-1:0] pin_func_i,
    input logic [NUM_LANES-1:0] pin_dir_i,
    input logic [NUM_LANES-1:0] pad_in_i,
    input logic                 tx_bclk_i,
    input logic                 tx_fs_i,
    input logic [NUM_LANES-1:0] rx_data_o,
    input logic                 rx_bclk_o,
    input logic [NUM_LANES-1:0] pad_oe_o,
    input logic                 lb_active_o,
    input logic                 cfg_err_o
);

    // R10
    hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fs_i |=> ($stable(lb_active_o) && $stable(cfg_err_o) && $stable(pad_oe_o)));

    // R2
    non_tdm_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fs_i && ((tx_mode_i < MODE_W'(TDM_MIN)) || (tx_mode_i > MODE_W'(TDM_MAX))))
        |=> !lb_active_o);

    // R9
    err_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> lb_active_o);

    // R8
    bclk_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_active_o |-> (rx_bclk_o == tx_bclk_i));

    // R6
    pad_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fs_i |=> (pad_oe_o == (~$past(pin_func_i) & $past(pin_dir_i))));

    // R1
    idle_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_active_o |-> (rx_data_o == pad_in_i));

endmodule

bind lbk_router lbk_router_chk #(.NUM_LANES(NUM_LANES)) u_chk (.*);

// File: tb/lbk_router_bench.sv
module lbk_router_bench;

    localparam int NL = 8;
    localparam int WB = 16;

    logic          clk = 0;
    logic          rst_n = 0;
    logic [7:0]    lb_ctrl = '0;
    logic [8:0]    tx_mode = '0;
    logic          tx_async = 0;
    logic [NL-1:0] pin_func = '1, pin_dir = '0;
    logic [NL-1:0] tx_data = '0, ext_bits = '0, pad_in;
    logic          tx_bclk = 0, tx_fs = 0, rx_bclk_pin = 0, rx_fs_pin = 0;
    logic [NL-1:0] rx_data, pad_out, pad_oe;
    logic          rx_bclk, rx_fs, lb_active, cfg_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [WB-1:0] txw [NL];
    logic [WB-1:0] extw[NL];
    logic [WB-1:0] rxw [NL];
    logic [WB-1:0] expw[NL];
    logic [NL-1:0] cur_func, cur_dir;

    always #2 clk = ~clk;

    // Pad ring: a driven pad reads back its own output, otherwise the outside value.
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_bits);

    lbk_router #(.NUM_LANES(NL)) u_lbk_router (
        .clk(clk), .rst_n(rst_n), .lb_ctrl_i(lb_ctrl), .tx_mode_i(tx_mode),
        .tx_async_i(tx_async), .pin_func_i(pin_func), .pin_dir_i(pin_dir),
        .tx_data_i(tx_data), .pad_in_i(pad_in), .tx_bclk_i(tx_bclk), .tx_fs_i(tx_fs),
        .rx_bclk_pin_i(rx_bclk_pin), .rx_fs_pin_i(rx_fs_pin), .rx_data_o(rx_data),
        .rx_bclk_o(rx_bclk), .rx_fs_o(rx_fs), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .lb_active_o(lb_active), .cfg_err_o(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Control word: bit0 enable, bit1 ordering, bits3:2 clock mode, bit4 pad-level.
    function automatic logic [7:0] mk_ctrl(bit en, bit ord, logic [1:0] ckm, bit lvl);
        return {3'b000, lvl, ckm, ord, en};
    endfunction

    task automatic apply_cfg(input logic [7:0] c, input logic [8:0] m, input bit as,
                             input logic [NL-1:0] f, input logic [NL-1:0] d);
        @(negedge clk);
        lb_ctrl = c; tx_mode = m; tx_async = as; pin_func = f; pin_dir = d;
        cur_func = f; cur_dir = d;
        tx_fs = 1;
        @(negedge clk);
        tx_fs = 0;
    endtask

    function automatic logic [WB-1:0] pad_word(int l);
        return (!cur_func[l] && cur_dir[l]) ? txw[l] : extw[l];
    endfunction

    task automatic send_words(input logic [WB-1:0] seed);
        for (int l = 0; l < NL; l++) begin
            txw[l]  = seed ^ WB'(l * 16'h1357) ^ 16'hA5C3;
            extw[l] = ~txw[l] ^ WB'(l);
            rxw[l]  = '0;
        end
        for (int b = WB - 1; b >= 0; b--) begin
            @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                tx_data[l]  = txw[l][b];
                ext_bits[l] = extw[l][b];
            end
            #1;
            for (int l = 0; l < NL; l++) rxw[l] = {rxw[l][WB-2:0], rx_data[l]};
        end
    endtask

    task automatic cmp_words(input string req);
        for (int l = 0; l < NL; l++)
            chk(rxw[l] == expw[l], req, $sformatf("rx word lane %0d", l), 32'(rxw[l]), 32'(expw[l]));
    endtask

    task automatic t_reset();
        chk(lb_active == 0, "R1", "lb_active after reset", 32'(lb_active), 0);
        chk(cfg_err == 0, "R1", "cfg_err after reset", 32'(cfg_err), 0);
        chk(pad_oe == '0, "R1", "pad_oe after reset", 32'(pad_oe), 0);
        rx_bclk_pin = 1; rx_fs_pin = 1; #1;
        chk(rx_bclk == 1 && rx_fs == 1, "R1", "rx clocks from pins", {30'd0, rx_bclk, rx_fs}, 3);
        rx_bclk_pin = 0; rx_fs_pin = 0;
        cur_func = '1; cur_dir = '0;
        send_words(16'h0101);
        for (int l = 0; l < NL; l++) expw[l] = extw[l];
        cmp_words("R1");
    endtask

    task automatic t_mode_gate();
        logic [8:0] bad_modes[3] = '{9'd0, 9'h180, 9'd33};
        foreach (bad_modes[i]) begin
            apply_cfg(mk_ctrl(1, 0, 2'd1, 0), bad_modes[i], 0, '0, '0);
            chk(lb_active == 0, "R2", $sformatf("inactive mode %0h", bad_modes[i]), 32'(lb_active), 0);
        end
        send_words(16'h2202);
        for (int l = 0; l < NL; l++) expw[l] = pad_word(l);
        cmp_words("R2");
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd2, 0, '0, '0);
        chk(lb_active == 1, "R2", "active at 2 slots", 32'(lb_active), 1);
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd32, 0, '0, '0);
        chk(lb_active == 1, "R2", "active at 32 slots", 32'(lb_active), 1);
        apply_cfg(mk_ctrl(0, 0, 2'd1, 0), 9'd8, 0, '0, '0);
        chk(lb_active == 0, "R2", "disabled", 32'(lb_active), 0);
    endtask

    task automatic t_internal();
        // R3 with all pins as GPIO inputs (R5: routing must not care)
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd8, 0, '1, '0);
        chk(pad_oe == '0, "R6", "oe off for GPIO pins", 32'(pad_oe), 0);
        send_words(16'h3303);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = txw[2*k+1]; expw[2*k+1] = pad_word(2*k+1);
        end
        cmp_words("R3_R5");
        // R4 with all pins serial outputs: data also visible on pads (R6)
        apply_cfg(mk_ctrl(1, 1, 2'd1, 0), 9'd4, 0, '0, '1);
        chk(pad_oe == '1, "R6", "oe on for serial outputs", 32'(pad_oe), 32'hFF);
        send_words(16'h4404);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = pad_word(2*k); expw[2*k+1] = txw[2*k];
        end
        cmp_words("R4");
        chk(pad_out == tx_data, "R6", "pad_out mirrors tx", 32'(pad_out), 32'(tx_data));
        // R5 mixed pin setup, ordering 0
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd16, 0, 8'h5A, 8'h3C);
        chk(pad_oe == (~8'h5A & 8'h3C), "R6", "oe mixed", 32'(pad_oe), 32'(~8'h5A & 8'h3C));
        send_words(16'h5505);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = txw[2*k+1]; expw[2*k+1] = pad_word(2*k+1);
        end
        cmp_words("R5");
    endtask

    task automatic t_pad_level();
        apply_cfg(mk_ctrl(1, 0, 2'd1, 1), 9'd8, 0, '0, 8'hAA);
        send_words(16'h6606);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = txw[2*k+1]; expw[2*k+1] = txw[2*k+1];
        end
        cmp_words("R7");
        apply_cfg(mk_ctrl(1, 1, 2'd1, 1), 9'd8, 0, '0, 8'h55);
        send_words(16'h7707);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = txw[2*k]; expw[2*k+1] = txw[2*k];
        end
        cmp_words("R7");
        // Wrong direction: source pads are inputs, so the outside words arrive.
        apply_cfg(mk_ctrl(1, 0, 2'd1, 1), 9'd8, 0, '0, '0);
        send_words(16'h8808);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = extw[2*k+1]; expw[2*k+1] = extw[2*k+1];
        end
        cmp_words("R7");
    endtask

    task automatic t_clocks();
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd8, 0, '0, '0);
        chk(cfg_err == 0, "R9", "sync setup no error", 32'(cfg_err), 0);
        @(negedge clk); tx_bclk = 1; rx_bclk_pin = 0; #1;
        chk(rx_bclk == 1, "R8", "rx bclk from tx", 32'(rx_bclk), 1);
        tx_bclk = 0; rx_bclk_pin = 1; #1;
        chk(rx_bclk == 0, "R8", "rx bclk from tx low", 32'(rx_bclk), 0);
        rx_fs_pin = 1; #1;
        chk(rx_fs == 0, "R8", "rx fs from tx", 32'(rx_fs), 0);
        rx_bclk_pin = 0; rx_fs_pin = 0;
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd8, 1, '0, '0);
        chk(cfg_err == 1, "R9", "async bit set", 32'(cfg_err), 1);
        apply_cfg(mk_ctrl(1, 0, 2'd2, 0), 9'd8, 0, '0, '0);
        chk(cfg_err == 1, "R9", "clock mode 2", 32'(cfg_err), 1);
        apply_cfg(mk_ctrl(1, 0, 2'd2, 0), 9'd0, 1, '0, '0);
        chk(cfg_err == 0, "R9", "no error when inactive", 32'(cfg_err), 0);
        @(negedge clk); tx_bclk = 1; rx_bclk_pin = 0; #1;
        chk(rx_bclk == 0, "R8", "rx bclk from pin when inactive", 32'(rx_bclk), 0);
        tx_bclk = 0;
    endtask

    task automatic t_boundary();
        apply_cfg(mk_ctrl(1, 0, 2'd1, 0), 9'd8, 0, '0, '0);
        @(negedge clk);
        lb_ctrl = mk_ctrl(0, 1, 2'd0, 1); tx_mode = 9'd0; tx_async = 1; pin_dir = '1;
        repeat (5) @(negedge clk);
        chk(lb_active == 1, "R10", "held without frame start", 32'(lb_active), 1);
        chk(pad_oe == '0, "R10", "oe held without frame start", 32'(pad_oe), 0);
        chk(cfg_err == 0, "R10", "err held without frame start", 32'(cfg_err), 0);
        cur_func = '0; cur_dir = '0;
        send_words(16'h9909);
        for (int k = 0; k < NL / 2; k++) begin
            expw[2*k] = txw[2*k+1]; expw[2*k+1] = extw[2*k+1];
        end
        cmp_words("R10");
        tx_fs = 1; @(negedge clk); tx_fs = 0;
        chk(lb_active == 0, "R10", "applied at frame start", 32'(lb_active), 0);
        chk(pad_oe == '1, "R10", "oe applied at frame start", 32'(pad_oe), 32'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_mode_gate();
        t_internal();
        t_pad_level();
        t_clocks();
        t_boundary();
        summary();
    end

    initial begin
        #(4 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

endmodule